// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the current word address for a synchronous memory that supports four-beat bursts. A start address is captured whenever either of two address-strobe acceptances is signalled. After that, the two least significant address bits step through a four-entry sequence on each cycle in which the active-low advance input is low. The bits above the low field keep the value captured at the load.

Two sequence orders are supported, chosen by a mode input. Linear order adds the beat count to the starting low bits and wraps modulo four. Interleaved order combines the beat count with the starting low bits by exclusive-or, which is the order a cache-line fill from a processor expects. Bursting is optional: a fresh load on every cycle overrides any advance, so random-access traffic behaves like a plain registered address.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr_out` is all zeros.
- R2: A high on either `start_p` or `start_c` at a rising edge captures `addr_in`, and `addr_out` equals that value after the edge.
- R3: Between loads, `addr_out[ADDR_W-1:2]` keeps the value captured at the most recent load.
- R4: With `order_sel` = 0 (linear), after n advances the low two bits equal (start low bits + n) modulo 4; from start 2 the sequence is 2,3,0,1.
- R5: With `order_sel` = 1 (interleaved), after n advances the low two bits equal start low bits XOR (n modulo 4); from start 1 the sequence is 1,0,3,2.
- R6: The fourth advance of a burst returns the low bits to the start value, so the fifth address of a burst repeats the first.
- R7: A load at the same edge as an advance (`adv_n` = 0) takes priority: `addr_out` becomes `addr_in` with no step applied.
- R8: With no load and `adv_n` = 1 at an edge, `addr_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_p | input | 1 | First address-strobe acceptance; loads `addr_in` |
| start_c | input | 1 | Second address-strobe acceptance; loads `addr_in` |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_in | input | ADDR_W | Start address for a load |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Every result is due one clock after the edge that samples its stimulus: a load or advance sampled at edge k is visible on `addr_out` just after edge k, and `order_sel` acts on the output combinationally within the same cycle. The bench drives inputs shortly after a rising edge, lets the next rising edge sample them, and compares `addr_out` a nanosecond later, so each comparison falls in the cycle the result belongs to. Bursts are walked for five beats in both orders and from several start values so that the wrap on the fifth address and the upper-bit retention are seen directly.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              start_c,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign load    = start_p | start_c;
  assign base_lo = base_q[BEAT_W-1:0];
  assign lin_lo  = base_lo + beat_q;
  assign ilv_lo  = base_lo ^ beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign addr_out = {base_q[ADDR_W-1 -: HI_W], order_sel ? ilv_lo : lin_lo};
endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_p,
  input logic              start_c,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  localparam logic [BEAT_W-1:0] ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  logic              ld;
  logic [BEAT_W-1:0] lo;
  assign ld = start_p | start_c;
  assign lo = addr_out[BEAT_W-1:0];

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> addr_out == $past(addr_in));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && !order_sel) |=> (order_sel || lo == $past(lo) + ONE));

  a_r5_interleaved_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && order_sel) |=> (!order_sel || lo != $past(lo)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> (order_sel != $past(order_sel) || $stable(addr_out)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_p(start_p), .start_c(start_c),
  .adv_n(adv_n), .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_p, start_c, adv_n, order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .start_c(start_c),
    .adv_n(adv_n), .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic idle();
    start_p = 0; start_c = 0; adv_n = 1;
  endtask

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, int n, logic ord);
    logic [1:0] lo;
    lo = ord ? (s[1:0] ^ 2'(n)) : 2'(s[1:0] + 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    rst_n = 0; idle(); order_sel = 0; addr_in = 19'h7ffff;
    step(); step();
    check("R1 in reset", '0);
    rst_n = 1;
    step();
    check("R1 after release", '0);
  endtask

  task automatic t_burst(string req, logic ord, logic [AW-1:0] s, bit via_c);
    order_sel = ord; addr_in = s;
    start_p = !via_c; start_c = via_c; adv_n = 1;
    step();
    check("R2 load", s);
    start_p = 0; start_c = 0;
    for (int n = 1; n <= 4; n++) begin
      adv_n = 0;
      step();
      check(n == 4 ? "R6 wrap" : req, beat_addr(s, n, ord));
      check("R3 upper bits", beat_addr(s, n, ord));
    end
    idle();
  endtask

  task automatic t_hold();
    order_sel = 1; addr_in = 19'h2a5c2; start_c = 1; adv_n = 1;
    step();
    start_c = 0; adv_n = 0;
    step();
    adv_n = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 hold", beat_addr(19'h2a5c2, 1, 1));
    end
    adv_n = 0;
    step();
    check("R5 resume", beat_addr(19'h2a5c2, 2, 1));
    idle();
  endtask

  task automatic t_override();
    order_sel = 0; addr_in = 19'h01233; start_p = 1; adv_n = 1;
    step();
    start_p = 0; adv_n = 0;
    step();
    check("R4 pre-override", 19'h01230);
    addr_in = 19'h40001; start_c = 1; adv_n = 0;
    step();
    check("R7 load beats advance", 19'h40001);
    addr_in = 19'h40006; start_c = 0; start_p = 1;
    step();
    check("R7 back-to-back load", 19'h40006);
    idle();
    step();
    check("R8 idle after load", 19'h40006);
  endtask

  initial begin
    t_reset();
    t_burst("R4 linear", 0, 19'h12342, 0);
    t_burst("R4 linear", 0, 19'h7fff3, 1);
    t_burst("R5 interleaved", 1, 19'h00001, 1);
    t_burst("R5 interleaved", 1, 19'h5a5a6, 0);
    t_burst("R5 interleaved", 1, 19'h33333, 0);
    t_hold();
    t_override();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule